// File: doc/BRIEF.md
# Attribute Store Write Sequencer

This block sits behind the card control strobes and runs every write into a 256-byte non-volatile attribute store. The store answers only in attribute space (space select low) and only at even byte addresses. The card address bits 8:1 pick the byte. A write is taken on the leading edge of the effective write pulse. That pulse is the AND of write enable, low-byte enable and attribute space, at an even address. On that edge the address and data are captured.

The program cycle starts when write enable or low-byte enable returns high. It then runs for a fixed number of clock cycles. While it runs, the ready line is low and any new write pulse is ignored. The captured byte reaches the array only when the cycle ends, so a read during the cycle still returns the old contents.

After reset, a lockout window keeps the block from accepting writes. At the end of that window a mode strap is sampled and then held. The block also drives out an inverted copy of reset, and a lockout-release flag that the common-memory path uses to gate its own writes. The attribute-protect input blocks every attribute write. A ready input from the common memory is merged into the ready output.

State machine, with the transitions that move it:
- LOCK → IDLE when the lockout count expires.
- IDLE → ARMED on an accepted leading edge.
- ARMED → PROG when a strobe is released.
- ARMED → IDLE on an abort, when the pulse ends through space select or A0.
- PROG → IDLE when the commit happens on the last program cycle.

Top module: `attr_nvm_seq`

## Requirements
- R1: `rst_n_out` is always the inverse of `rst`. While `rst` is high, `wr_unlock` and `strap_held` are 0.
- R2: After `rst` falls, `wr_unlock` stays 0 for exactly LOCK_CYC rising clock edges and then becomes 1. A write pulse made while `wr_unlock` is 0 starts no program cycle, so `ready_out` does not drop.
- R3: `strap_held` takes the value of `strap_in` at the edge where lockout ends. After that it ignores `strap_in` until the next reset.
- R4: A write to the store has `space_n`=0, `card_addr[0]`=0, `ce_lo_n`=0 and a falling `we_n`. The byte index is `card_addr[8:1]`. The data stored is `wdata` as sampled at the first clock edge that sees the pulse. Later changes to `wdata` have no effect.
- R5: The program cycle begins at the first clock edge that sees `we_n` or `ce_lo_n` high after an accepted pulse. Either strobe may be released first. The internal busy lasts exactly PROG_CYC clock cycles.
- R6: `ready_out` is 1 only when `ext_ready` is 1 and no program cycle is running.
- R7: A write pulse made during a program cycle is ignored. It neither changes the target byte nor extends the busy time.
- R8: When `attr_prot` is 1 at the leading edge, the write is dropped. No busy is raised and the byte is unchanged.
- R9: A write pulse with `card_addr[0]`=1 or with `space_n`=1 does not touch the store and raises no busy.
- R10: A read (`oe_n`, `ce_lo_n`, `space_n`, `card_addr[0]` all 0) returns the byte at `card_addr[8:1]` on `rdata`, with `rdata_oe`=1. During a program cycle it returns the byte's previous contents. After the cycle it returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Active-high reset |
| space_n | input | 1 | Space select, low = attribute space |
| ce_lo_n | input | 1 | Low-byte enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| card_addr | input | 9 | Card address bits 8:0; bit 0 selects the odd byte |
| wdata | input | 8 | Write data on the low byte lane |
| attr_prot | input | 1 | Attribute write protect, high blocks writes |
| ext_ready | input | 1 | Common-memory ready, low = busy |
| strap_in | input | 1 | Mode strap pin |
| rdata | output | 8 | Read data from the store |
| rdata_oe | output | 1 | High while a store read is selected |
| ready_out | output | 1 | Merged ready, low = busy |
| wr_unlock | output | 1 | High once the lockout window has elapsed |
| strap_held | output | 1 | Strap value held at the end of lockout |
| rst_n_out | output | 1 | Inverted reset for the memory array |

## Verification
If the sequencer gets stuck in ARMED or PROG, `ready_out` shows it. The ready line either stays low past PROG_CYC cycles or never falls after a valid pulse, so a wrong program length shows up within one cycle of the expected release. If the capture or commit path is wrong, the next read of the byte returns the wrong value. That read can be made during the same program cycle or right after it. A fault in the lockout counter shows one edge early or late on `wr_unlock`, and a fault in the strap latch shows on `strap_held` when `strap_in` is toggled after lockout.

// File: rtl/attr_seq_pkg.sv
package attr_seq_pkg;
    typedef enum logic [1:0] {
        ST_LOCK  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_PROG  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/attr_strobe_dec.sv
module attr_strobe_dec (
    input  logic clk,
    input  logic rst,
    input  logic space_n,
    input  logic ce_lo_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic a0,
    output logic wr_lead,
    output logic wr_active,
    output logic strobe_up,
    output logic rd_sel
);
    logic pulse_now;
    logic pulse_q;

    // Effective write pulse: attribute space, even byte, both strobes low
    assign pulse_now = ~space_n & ~a0 & ~ce_lo_n & ~we_n;

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= pulse_now;
    end

    assign wr_lead   = pulse_now & ~pulse_q;
    assign wr_active = pulse_now;
    assign strobe_up = we_n | ce_lo_n;
    assign rd_sel    = ~space_n & ~a0 & ~ce_lo_n & ~oe_n;
endmodule

// File: rtl/attr_seq_fsm.sv
module attr_seq_fsm
    import attr_seq_pkg::*;
#(
    parameter int PROG_CYC = 1000000,
    parameter int LOCK_CYC = 300000
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_lead,
    input  logic wr_active,
    input  logic strobe_up,
    input  logic attr_prot,
    input  logic strap_in,
    output logic busy,
    output logic unlocked,
    output logic strap_held,
    output logic cap_en,
    output logic commit
);
    localparam int MAX_CYC = (PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYC - 1);

    seq_state_t state, nxt;
    logic [CNT_W-1:0] cnt;
    logic lock_done;
    logic prog_done;

    assign lock_done = (state == ST_LOCK) && (cnt == LOCK_LAST);
    assign prog_done = (state == ST_PROG) && (cnt == PROG_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOCK;
        else     state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOCK:  if (lock_done) nxt = ST_IDLE;
            ST_IDLE:  if (wr_lead && !attr_prot) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!wr_active) nxt = strobe_up ? ST_PROG : ST_IDLE;
            end
            ST_PROG:  if (prog_done) nxt = ST_IDLE;
            default:  nxt = ST_LOCK;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = 1'b0;
        unlocked = 1'b1;
        cap_en   = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_LOCK:  unlocked = 1'b0;
            ST_IDLE:  cap_en   = wr_lead & ~attr_prot;
            ST_ARMED: ;
            ST_PROG:  begin
                busy   = 1'b1;
                commit = prog_done;
            end
            default:  unlocked = 1'b0;
        endcase
    end

    // Shared lockout / program timer
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (lock_done || prog_done || nxt == ST_ARMED) begin
            cnt <= '0;
        end else if (state == ST_LOCK || state == ST_PROG) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strap latch at the end of lockout
    always_ff @(posedge clk) begin
        if (rst)            strap_held <= 1'b0;
        else if (lock_done) strap_held <= strap_in;
    end
endmodule

// File: rtl/attr_store.sv
module attr_store #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              commit,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  lat_idx;
    logic [DATA_W-1:0] lat_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_idx  <= '0;
            lat_data <= '0;
        end else if (cap_en) begin
            lat_idx  <= cap_idx;
            lat_data <= cap_data;
        end
    end

    // Array content is non-volatile: not cleared by reset
    always_ff @(posedge clk) begin
        if (commit) mem[lat_idx] <= lat_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/attr_nvm_seq.sv
module attr_nvm_seq #(
    parameter int IDX_W    = 8,
    parameter int DATA_W   = 8,
    parameter int PROG_CYC = 1000000,
    parameter int LOCK_CYC = 300000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              space_n,
    input  logic              ce_lo_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [IDX_W:0]    card_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              attr_prot,
    input  logic              ext_ready,
    input  logic              strap_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              ready_out,
    output logic              wr_unlock,
    output logic              strap_held,
    output logic              rst_n_out
);
    logic wr_lead, wr_active, strobe_up, rd_sel;
    logic busy, cap_en, commit;
    logic [DATA_W-1:0] store_q;

    attr_strobe_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .space_n   (space_n),
        .ce_lo_n   (ce_lo_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .a0        (card_addr[0]),
        .wr_lead   (wr_lead),
        .wr_active (wr_active),
        .strobe_up (strobe_up),
        .rd_sel    (rd_sel)
    );

    attr_seq_fsm #(
        .PROG_CYC (PROG_CYC),
        .LOCK_CYC (LOCK_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_lead    (wr_lead),
        .wr_active  (wr_active),
        .strobe_up  (strobe_up),
        .attr_prot  (attr_prot),
        .strap_in   (strap_in),
        .busy       (busy),
        .unlocked   (wr_unlock),
        .strap_held (strap_held),
        .cap_en     (cap_en),
        .commit     (commit)
    );

    attr_store #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_idx  (card_addr[IDX_W:1]),
        .cap_data (wdata),
        .commit   (commit),
        .rd_idx   (card_addr[IDX_W:1]),
        .rd_data  (store_q)
    );

    assign rdata     = rd_sel ? store_q : '0;
    assign rdata_oe  = rd_sel;
    assign ready_out = ext_ready & ~busy;
    assign rst_n_out = ~rst;
endmodule

// File: rtl/attr_seq_chk.sv
module attr_seq_chk #(
    parameter int PROG_CYC = 1000000
) (
    input logic clk,
    input logic rst,
    input logic we_n,
    input logic ce_lo_n,
    input logic ext_ready,
    input logic ready_out,
    input logic prog_busy,
    input logic wr_unlock,
    input logic strap_held
);
    int unsigned run;

    always_ff @(posedge clk) begin
        if (rst)            run <= 0;
        else if (prog_busy) run <= run + 1;
        else                run <= 0;
    end

    a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_busy) |-> run == PROG_CYC);

    a_r5_busy_bound: assert property (@(posedge clk) disable iff (rst)
        run <= PROG_CYC);

    a_r5_start_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_busy) |-> $past(we_n || ce_lo_n));

    a_r2_locked_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_unlock |-> !prog_busy);

    a_r2_unlock_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(wr_unlock) |-> wr_unlock);

    a_r3_strap_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_unlock && $past(wr_unlock)) |-> $stable(strap_held));

    a_r6_ready_merge: assert property (@(posedge clk) disable iff (rst)
        ready_out |-> (ext_ready && !prog_busy));
endmodule

bind attr_nvm_seq attr_seq_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .we_n       (we_n),
    .ce_lo_n    (ce_lo_n),
    .ext_ready  (ext_ready),
    .ready_out  (ready_out),
    .prog_busy  (busy),
    .wr_unlock  (wr_unlock),
    .strap_held (strap_held)
);

// File: tb/sim_attr_nvm_seq.sv
`timescale 1ns/1ps
module sim_attr_nvm_seq;
    localparam int PROG_CYC = 20;
    localparam int LOCK_CYC = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic space_n = 1'b1, ce_lo_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [8:0] card_addr = '0;
    logic [7:0] wdata = '0;
    logic attr_prot = 1'b0, ext_ready = 1'b1, strap_in = 1'b0;
    logic [7:0] rdata;
    logic rdata_oe, ready_out, wr_unlock, strap_held, rst_n_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [256];
    bit         known [256];

    always #5 clk = ~clk;

    attr_nvm_seq #(.PROG_CYC(PROG_CYC), .LOCK_CYC(LOCK_CYC)) u0 (
        .clk(clk), .rst(rst), .space_n(space_n), .ce_lo_n(ce_lo_n),
        .oe_n(oe_n), .we_n(we_n), .card_addr(card_addr), .wdata(wdata),
        .attr_prot(attr_prot), .ext_ready(ext_ready), .strap_in(strap_in),
        .rdata(rdata), .rdata_oe(rdata_oe), .ready_out(ready_out),
        .wr_unlock(wr_unlock), .strap_held(strap_held), .rst_n_out(rst_n_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_busy(input bit prot, input bit a0, input bit sp);
        return (!prot && !a0 && !sp) ? PROG_CYC : 0;
    endfunction

    function automatic bit exp_ready(input bit ext, input bit in_prog);
        return ext && !in_prog;
    endfunction

    task automatic pulse_write(input logic [8:0] a, input logic [7:0] d,
                               input bit use_ce, input bit sp);
        @(negedge clk);
        card_addr = a; wdata = d; space_n = sp; ce_lo_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); wdata = ~d;          // change after capture edge
        @(negedge clk);
        if (use_ce) ce_lo_n = 1'b1; else we_n = 1'b1;
    endtask

    task automatic check_busy(input int exp, input string tag);
        int lows = 0;
        repeat (PROG_CYC + 4) begin
            @(negedge clk);
            we_n = 1'b1; ce_lo_n = 1'b1; space_n = 1'b1; oe_n = 1'b1;
            if (!ready_out) lows++;
        end
        check(lows == exp, tag, lows, exp);
    endtask

    task automatic rd_check(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        @(negedge clk);
        card_addr = {idx, 1'b0}; space_n = 1'b0; ce_lo_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check(rdata_oe === 1'b1 && rdata === exp, tag, rdata, exp);
    endtask

    task automatic wait_ready();
        for (int k = 0; k < PROG_CYC + 10 && !ready_out; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) known[i] = 1'b0;

        // R1: reset state
        strap_in = 1'b1;
        repeat (3) @(negedge clk);
        check(rst_n_out === 1'b0, "R1 rst_n_out in reset", rst_n_out, 0);
        check(wr_unlock === 1'b0 && strap_held === 1'b0, "R1 unlock/strap in reset",
              {wr_unlock, strap_held}, 0);
        rst = 1'b0;
        #1;
        check(rst_n_out === 1'b1, "R1 rst_n_out after reset", rst_n_out, 1);

        // R2: lockout window with a write attempt inside it
        begin
            int lows = 0;
            for (int i = 1; i <= LOCK_CYC - 1; i++) begin
                @(negedge clk);
                if (i == 1) begin
                    card_addr = 9'h010; wdata = 8'hAA; space_n = 1'b0; ce_lo_n = 1'b0; we_n = 1'b0;
                end
                if (i == 3) we_n = 1'b1;
                if (i == 4) begin ce_lo_n = 1'b1; space_n = 1'b1; end
                if (!ready_out) lows++;
            end
            check(wr_unlock === 1'b0, "R2 still locked at LOCK_CYC-1", wr_unlock, 0);
            @(negedge clk);
            check(wr_unlock === 1'b1, "R2 unlocked at LOCK_CYC", wr_unlock, 1);
            check(strap_held === 1'b1, "R3 strap sampled", strap_held, 1);
            strap_in = 1'b0;
            repeat (PROG_CYC) begin
                @(negedge clk);
                if (!ready_out) lows++;
            end
            check(lows == 0, "R2 locked write ignored", lows, 0);
            check(strap_held === 1'b1, "R3 strap held after change", strap_held, 1);
        end

        // R4/R5: directed writes, we_n release and ce_lo_n release
        pulse_write(9'h020, 8'h11, 1'b0, 1'b0);
        check_busy(exp_busy(0, 0, 0), "R5 busy length we release");
        model[8'h10] = 8'h11; known[8'h10] = 1'b1;
        rd_check(8'h10, 8'h11, "R4 data from leading edge");
        pulse_write(9'h022, 8'h22, 1'b1, 1'b0);
        check_busy(exp_busy(0, 0, 0), "R5 busy length ce release");
        model[8'h11] = 8'h22; known[8'h11] = 1'b1;
        rd_check(8'h11, 8'h22, "R4 write via ce release");

        // R10 and R7: read during program, write during program
        pulse_write(9'h020, 8'h5A, 1'b0, 1'b0);
        pulse_write(9'h022, 8'hC3, 1'b0, 1'b0);
        rd_check(8'h10, 8'h11, "R10 old value during program");
        check(ready_out === 1'b0, "R6 ready low while busy", ready_out, 0);
        wait_ready();
        model[8'h10] = 8'h5A;
        rd_check(8'h10, 8'h5A, "R10 new value after program");
        rd_check(8'h11, 8'h22, "R7 write during program ignored");
        check_busy(0, "R7 no extra busy");

        // R6: external ready merge
        @(negedge clk); ext_ready = 1'b0; #1;
        check(ready_out === exp_ready(0, 0), "R6 ext busy shows", ready_out, 0);
        @(negedge clk); ext_ready = 1'b1; #1;
        check(ready_out === exp_ready(1, 0), "R6 ready restored", ready_out, 1);

        // R8: protected write
        attr_prot = 1'b1;
        pulse_write(9'h020, 8'hEE, 1'b0, 1'b0);
        check_busy(exp_busy(1, 0, 0), "R8 protect no busy");
        attr_prot = 1'b0;
        rd_check(8'h10, 8'h5A, "R8 byte unchanged");

        // R9: odd address and common space
        pulse_write(9'h021, 8'h77, 1'b0, 1'b0);
        check_busy(exp_busy(0, 1, 0), "R9 odd address no busy");
        pulse_write(9'h020, 8'h66, 1'b0, 1'b1);
        check_busy(exp_busy(0, 0, 1), "R9 common space no busy");
        rd_check(8'h10, 8'h5A, "R9 byte unchanged");

        // Random writes (R4 R5 R8)
        for (int n = 0; n < 24; n++) begin
            logic [7:0] idx = 8'($urandom);
            logic [7:0] d   = 8'($urandom);
            bit use_ce = 1'($urandom);
            bit prot   = ($urandom % 8) == 0;
            attr_prot = prot;
            pulse_write({idx, 1'b0}, d, use_ce, 1'b0);
            check_busy(exp_busy(prot, 0, 0), "R5 random busy length");
            attr_prot = 1'b0;
            if (!prot) begin model[idx] = d; known[idx] = 1'b1; end
        end
        for (int i = 0; i < 256; i++)
            if (known[i]) rd_check(8'(i), model[i], "R4 random readback");

        @(negedge clk);
        finish_up();
    end
endmodule